// File: doc/BRIEF.md
# Byte-Parallel Self-Synchronizing x^43+1 Payload Scrambler

This block randomizes cell payload bytes with the self-synchronizing polynomial x^43+1, or removes that randomization on the receive side. One byte moves through per clock. A mode input picks the direction. In scramble mode, each output bit is the input bit XOR the output bit produced 43 bit-times earlier, so the block feeds back its own output. In descramble mode, each output bit is the received bit XOR the received bit from 43 bit-times earlier, so the line is fed forward. Because of this, a descrambler locks to any scrambler once 43 bits have passed, whatever either one held before.

The serial recursion is unrolled across the byte. Bit 7 of each byte is the first bit in serial order. A 43-bit history register keeps the most recent serial bits and advances by one byte on each accepted payload byte. An upstream framer marks payload bytes with a payload flag. Header bytes and idle cycles pass through unchanged, and the scrambler state is frozen while they do. Both output ports are registered, with one clock of latency.

Top module: `x43_payload_scrambler`

## Requirements
- R1: A synchronous reset clears the 43-bit history to zero and drives `out_valid` low. After reset, the first five accepted payload bytes come out equal to their input bytes in either mode.
- R2: `out_valid` in cycle n+1 equals `in_valid` in cycle n. When `in_valid` is high, `out_data` in cycle n+1 is the result for the byte presented in cycle n.
- R3: A valid byte with `pay_en` low leaves the block unchanged: `out_data` equals `in_data`.
- R4: Bytes with `pay_en` low and cycles with `in_valid` low do not advance or alter the history. The next payload byte is processed as if those bytes had never arrived.
- R5: Scramble mode (`scr_mode`=1): in the serial stream, taking bit 7 first, each output bit equals the input bit XOR the output bit 43 positions earlier.
- R6: Descramble mode (`scr_mode`=0): each output bit equals the received bit XOR the received bit 43 positions earlier in the same serial order.
- R7: A scrambler feeding a descrambler restores the original payload bytes exactly once 43 bits have passed, whatever the starting state of either instance.
- R8: A reset asserted in the middle of a stream discards all history. The five payload bytes that follow pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | DATA_W | Input byte, bit 7 first in serial order |
| pay_en | input | 1 | High for payload bytes. Low bytes pass through unchanged. |
| scr_mode | input | 1 | 1 = scramble (feedback), 0 = descramble (feed-forward) |
| out_valid | output | 1 | Output byte strobe, one clock after `in_valid` |
| out_data | output | DATA_W | Output byte |

## Verification
The bench builds two instances with the default parameters: an 8-bit datapath and a 43-stage history. Because the tap distance is larger than the byte width, every tap falls inside the stored history rather than inside the current byte. This exercises the unrolled tap indexing at its extremes: bit 7 reads the oldest stage and bit 0 reads stage 35. The second instance descrambles the first instance's output. This lets the bench check lock-up from arbitrary states after six bytes. A serial bit-by-bit model gives the expected value for every other byte. It is fed by a stimulus table that mixes modes, header bytes and idle cycles.

// File: rtl/x43_scr_pkg.sv
package x43_scr_pkg;
  typedef enum logic {
    MODE_DESCR = 1'b0,
    MODE_SCR   = 1'b1
  } scr_mode_e;
endpackage

// File: rtl/x43_unroll.sv
// Combinational unrolling of the serial recursion over one byte.
// ext holds history (older, high indices) above the byte (newest, index 0).
module x43_unroll #(
  parameter int DATA_W = 8,
  parameter int TAP    = 43
) (
  input  logic [TAP-1:0]    hist,
  input  logic [DATA_W-1:0] din,
  input  logic              scr_mode,
  input  logic              active,
  output logic [DATA_W-1:0] dout,
  output logic [TAP-1:0]    hist_nxt
);
  import x43_scr_pkg::*;

  localparam int EXT_W = TAP + DATA_W;

  logic [EXT_W-1:0] ext;
  logic             tap_bit;
  logic             mixed;

  always_comb begin
    ext     = {hist, {DATA_W{1'b0}}};
    dout    = din;
    tap_bit = 1'b0;
    mixed   = 1'b0;
    for (int k = DATA_W - 1; k >= 0; k--) begin
      tap_bit = ext[k + TAP];
      mixed   = din[k] ^ tap_bit;
      dout[k] = active ? mixed : din[k];
      ext[k]  = (scr_mode_e'(scr_mode) == MODE_SCR) ? mixed : din[k];
    end
    hist_nxt = ext[TAP-1:0];
  end
endmodule

// File: rtl/x43_history.sv
module x43_history #(
  parameter int TAP = 43
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [TAP-1:0] d,
  output logic [TAP-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/x43_out_stage.sv
module x43_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              v_in,
  input  logic [DATA_W-1:0] d_in,
  output logic              v_out,
  output logic [DATA_W-1:0] d_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v_out <= 1'b0;
      d_out <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) d_out <= d_in;
    end
  end
endmodule

// File: rtl/x43_payload_scrambler.sv
module x43_payload_scrambler #(
  parameter int DATA_W = 8,
  parameter int TAP    = 43
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              pay_en,
  input  logic              scr_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [TAP-1:0]    hist_q;
  logic [TAP-1:0]    hist_d;
  logic [DATA_W-1:0] mix_data;
  logic              take;

  assign take = in_valid & pay_en;

  x43_unroll #(.DATA_W(DATA_W), .TAP(TAP)) u_unroll (
    .hist     (hist_q),
    .din      (in_data),
    .scr_mode (scr_mode),
    .active   (take),
    .dout     (mix_data),
    .hist_nxt (hist_d)
  );

  x43_history #(.TAP(TAP)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .load (take),
    .d    (hist_d),
    .q    (hist_q)
  );

  x43_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .v_in  (in_valid),
    .d_in  (mix_data),
    .v_out (out_valid),
    .d_out (out_data)
  );
endmodule

// File: rtl/x43_payload_scrambler_chk.sv
module x43_payload_scrambler_chk #(
  parameter int DATA_W = 8,
  parameter int TAP    = 43
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              pay_en,
  input logic              scr_mode,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [TAP-1:0]    hist_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (hist_q == '0 && !out_valid)); // R1
  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
  AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
  AST_HEADER_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pay_en) |=> out_data == $past(in_data)); // R3
  AST_HIST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && pay_en) |=> $stable(hist_q)); // R4
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pay_en) |=> hist_q[TAP-1:DATA_W] == $past(hist_q[TAP-1-DATA_W:0])); // R4
  AST_SCR_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pay_en && scr_mode) |=> hist_q[DATA_W-1:0] == out_data); // R5
  AST_DESCR_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pay_en && !scr_mode) |=> hist_q[DATA_W-1:0] == $past(in_data)); // R6
endmodule

bind x43_payload_scrambler x43_payload_scrambler_chk #(.DATA_W(DATA_W), .TAP(TAP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .pay_en    (pay_en),
  .scr_mode  (scr_mode),
  .out_valid (out_valid),
  .out_data  (out_data),
  .hist_q    (hist_q)
);

// File: tb/x43_payload_scrambler_test.sv
`timescale 1ns/1ps
module x43_payload_scrambler_test;
  localparam int DW = 8;
  localparam int TP = 43;
  localparam int NV = 20;
  // {valid, pay_en, mode, data}
  localparam logic [10:0] VEC [NV] = '{
    {3'b111, 8'hA5}, {3'b111, 8'h3C}, {3'b101, 8'hFF}, {3'b111, 8'h00},
    {3'b011, 8'h77}, {3'b111, 8'h81}, {3'b111, 8'h5A}, {3'b111, 8'hC3},
    {3'b100, 8'h12}, {3'b110, 8'h9E}, {3'b110, 8'h01}, {3'b000, 8'hEE},
    {3'b110, 8'h80}, {3'b110, 8'h7F}, {3'b100, 8'h44}, {3'b110, 8'hB2},
    {3'b111, 8'h6D}, {3'b111, 8'hF0}, {3'b111, 8'h0F}, {3'b110, 8'hD4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, pay_en = 1'b0, scr_mode = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic out_valid, peer_valid;
  logic [DW-1:0] out_data, peer_data;

  int checks = 0, errors = 0;
  logic [TP-1:0] mh = '0;
  logic [DW-1:0] exp_b;
  logic [DW-1:0] sent [16];

  always #2.5 clk = ~clk;

  x43_payload_scrambler #(.DATA_W(DW), .TAP(TP)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .pay_en(pay_en), .scr_mode(scr_mode),
    .out_valid(out_valid), .out_data(out_data));

  x43_payload_scrambler #(.DATA_W(DW), .TAP(TP)) peer (
    .clk(clk), .rst(1'b0), .in_valid(out_valid), .in_data(out_data),
    .pay_en(1'b1), .scr_mode(1'b0),
    .out_valid(peer_valid), .out_data(peer_data));

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Serial reference: bit 7 first, one bit per step.
  task automatic model(input logic en, input logic md, input logic [DW-1:0] d, output logic [DW-1:0] o);
    o = d;
    if (en) begin
      for (int k = DW - 1; k >= 0; k--) begin
        o[k] = d[k] ^ mh[TP-1];
        mh = {mh[TP-2:0], md ? o[k] : d[k]};
      end
    end
  endtask

  task automatic put(input logic v, input logic e, input logic m, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = v; pay_en = e; scr_mode = m; in_data = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
    mh = '0;
    check(out_valid == 1'b0, "R1 valid low after reset", {7'b0, out_valid}, 8'h00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: first five payload bytes after reset are unchanged
    for (int i = 0; i < 5; i++) begin
      logic [DW-1:0] d;
      d = 8'h1B + 8'(i * 53);
      put(1'b1, 1'b1, i[0], d);
      model(1'b1, i[0], d, exp_b);
      check(out_data == d, "R1 passthrough after reset", out_data, d);
    end
    // Table walk: R2, R3, R5, R6
    for (int i = 0; i < NV; i++) begin
      logic v, e, m;
      logic [DW-1:0] d;
      {v, e, m, d} = VEC[i];
      put(v, e, m, d);
      check(out_valid == v, "R2 valid latency", {7'b0, out_valid}, {7'b0, v});
      if (v) begin
        model(e, m, d, exp_b);
        if (!e) check(out_data == d, "R3 header unchanged", out_data, d);
        else if (m) check(out_data == exp_b, "R5 scramble", out_data, exp_b);
        else check(out_data == exp_b, "R6 descramble", out_data, exp_b);
      end
    end
    // R4: header bytes and idles leave the history untouched
    for (int i = 0; i < 12; i++) begin
      logic [DW-1:0] d;
      d = 8'h90 ^ 8'(i * 29);
      if (i % 3 == 1) put(1'b1, 1'b0, 1'b1, 8'hFF);
      if (i % 4 == 2) put(1'b0, 1'b1, 1'b1, 8'hAA);
      put(1'b1, 1'b1, 1'b1, d);
      model(1'b1, 1'b1, d, exp_b);
      check(out_data == exp_b, "R4 state frozen across gaps", out_data, exp_b);
    end
    // R7: round trip through the peer descrambler
    for (int i = 0; i < 16; i++) begin
      sent[i] = 8'h05 + 8'(i * 37);
      put(1'b1, 1'b1, 1'b1, sent[i]);
      model(1'b1, 1'b1, sent[i], exp_b);
      if (i >= 7) begin
        check(peer_valid == 1'b1, "R7 peer valid", {7'b0, peer_valid}, 8'h01);
        check(peer_data == sent[i-1], "R7 round trip", peer_data, sent[i-1]);
      end
    end
    // R8: reset in mid-stream discards history
    do_reset();
    for (int i = 0; i < 5; i++) begin
      logic [DW-1:0] d;
      d = 8'hE7 - 8'(i * 19);
      put(1'b1, 1'b1, 1'b1, d);
      model(1'b1, 1'b1, d, exp_b);
      check(out_data == d, "R8 passthrough after mid-stream reset", out_data, d);
    end
    put(1'b1, 1'b1, 1'b1, 8'h3D);
    model(1'b1, 1'b1, 8'h3D, exp_b);
    check(out_data == exp_b, "R8 scrambling resumes", out_data, exp_b);
    finish_run();
  end
endmodule